// File: doc/BRIEF.md
# One-Hot Shift Sequencer with Priority-Free Output Select

This block is a fixed-length sequencer whose state is a chain of 62 flags, at most one of which is set. A start pulse plants a single set flag at the head of the chain. After that the flag walks one position per clock until it falls off the far end. The chain then stays empty until the next start. There is no state encoding to decode: each flag is the state.

The block drives an output bus from two data sources according to which flags are set. Flags 33 through 36 form the group that selects source A, and flag 37 alone selects source B. Each source is gated by the OR of its own flag group, and the gated results are ORed together. No group outranks another, because the chain never holds two set flags. When no selecting flag is set, the bus is zero. A status output goes high if more than one flag is ever set at once.

A start pulse that arrives mid-sequence restarts the run. On the next clock the chain holds only the head flag. This is the one way the block departs from plain shifting.

Top module: `onehot_seq_top`

## Requirements
- R1: While `rst` is sampled high, all flags clear on that clock; afterwards `dout` is zero and `multi_hot` is low.
- R2: A `start` sampled high with `rst` low sets flag 0 and only flag 0 on that clock edge. Call the cycle after that edge cycle 0. With `start` low, each later edge moves the set flag up by one index, so cycle n has flag n set.
- R3: In cycles 33, 34, 35 and 36 after a start, `dout` equals `src_a`.
- R4: In cycle 37 after a start, `dout` equals `src_b`.
- R5: In every other cycle `dout` is zero: cycles 0 to 32, cycles 38 to 61, and idle periods. This holds for any values on `src_a` and `src_b`.
- R6: After flag 61 shifts out (cycle 62 onward), the chain stays empty and `dout` stays zero until the next `start`. A later start repeats R2 to R5 exactly.
- R7: A `start` sampled during a running sequence discards the current position. The next cycle is cycle 0 of a new run.
- R8: `multi_hot` is high exactly when two or more flags are set. Under any sequence of `rst` and `start`, it stays low.
- R9: When `rst` and `start` are sampled high on the same edge, reset wins: the chain is empty afterwards and no run begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start or restart pulse |
| src_a | input | DATA_W (16) | Data source chosen by flags 33 to 36 |
| src_b | input | DATA_W (16) | Data source chosen by flag 37 |
| dout | output | DATA_W (16) | AND-OR selected output bus, zero when unselected |
| multi_hot | output | 1 | High when more than one flag is set |

## Verification
Two functions can fall in the same cycle: a restart injection, and a source selection that is already driving the bus. The bench provokes this by raising `start` in cycle 35 while `dout` carries `src_a`. In that cycle it checks that the bus still shows A. It then checks that the following cycle is cycle 0 of a fresh run (bus zero), and that A and B reappear at cycles 33 and 37 counted from the restart. Reset and start are also raised together in the middle of the A window. The judgement is a zero bus for the next forty cycles, proving that no run began.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int unsigned SEQ_STATES  = 62;
    localparam int unsigned SEQ_DATA_W  = 16;
    localparam int unsigned SEQ_NUM_SRC = 2;

    // Default flag windows for the two sources
    localparam int unsigned GRP_A_FIRST = 33;
    localparam int unsigned GRP_A_LAST  = 36;
    localparam int unsigned GRP_B_FIRST = 37;
    localparam int unsigned GRP_B_LAST  = 37;

    // What the chain does on the next edge
    typedef enum logic [1:0] {
        OP_SHIFT = 2'd0,
        OP_LOAD  = 2'd1,
        OP_CLEAR = 2'd2
    } chain_op_e;

    // Reset outranks start; otherwise plain shift
    function automatic chain_op_e pick_op(input logic rst, input logic start);
        if (rst)        return OP_CLEAR;
        else if (start) return OP_LOAD;
        else            return OP_SHIFT;
    endfunction

    // Per-source select bundle
    typedef struct packed {
        logic hit_b;
        logic hit_a;
    } src_sel_t;

endpackage

// File: rtl/seq_flag_chain.sv
module seq_flag_chain
    import seq_pkg::*;
#(
    parameter int unsigned NUM_STATES = SEQ_STATES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    output logic [NUM_STATES-1:0] flags
);

    localparam logic [NUM_STATES-1:0] HEAD = NUM_STATES'(1);

    logic [NUM_STATES-1:0] flags_q;
    logic [NUM_STATES-1:0] flags_d;
    chain_op_e             op;

    always_comb begin
        op = pick_op(rst, start);
        unique case (op)
            OP_CLEAR: flags_d = '0;
            OP_LOAD:  flags_d = HEAD;
            default:  flags_d = {flags_q[NUM_STATES-2:0], 1'b0};
        endcase
    end

    always_ff @(posedge clk) begin
        flags_q <= flags_d;
    end

    assign flags = flags_q;

endmodule

// File: rtl/seq_group_decode.sv
module seq_group_decode #(
    parameter int unsigned NUM_STATES = 62,
    parameter int unsigned FIRST      = 33,
    parameter int unsigned LAST       = 36
) (
    input  logic [NUM_STATES-1:0] flags,
    output logic                  hit
);

    logic [NUM_STATES-1:0] mask;

    for (genvar i = 0; i < NUM_STATES; i++) begin : g_mask
        assign mask[i] = (i >= FIRST && i <= LAST) ? 1'b1 : 1'b0;
    end

    assign hit = |(flags & mask);

endmodule

// File: rtl/seq_andor_mux.sv
module seq_andor_mux #(
    parameter int unsigned NUM_SRC = 2,
    parameter int unsigned W       = 16
) (
    input  logic [NUM_SRC-1:0][W-1:0] src,
    input  logic [NUM_SRC-1:0]        sel,
    output logic [W-1:0]              y
);

    logic [NUM_SRC-1:0][W-1:0] gated;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
        assign gated[i] = src[i] & {W{sel[i]}};
    end

    always_comb begin
        y = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            y = y | gated[i];
        end
    end

endmodule

// File: rtl/seq_onehot_watch.sv
module seq_onehot_watch #(
    parameter int unsigned NUM_STATES = 62
) (
    input  logic [NUM_STATES-1:0] flags,
    output logic                  multi
);

    // Clearing the lowest set bit leaves something only if two or more were set
    assign multi = |(flags & (flags - NUM_STATES'(1)));

endmodule

// File: rtl/onehot_seq_top.sv
module onehot_seq_top
    import seq_pkg::*;
#(
    parameter int unsigned NUM_STATES = SEQ_STATES,
    parameter int unsigned DATA_W     = SEQ_DATA_W,
    parameter int unsigned A_FIRST    = GRP_A_FIRST,
    parameter int unsigned A_LAST     = GRP_A_LAST,
    parameter int unsigned B_FIRST    = GRP_B_FIRST,
    parameter int unsigned B_LAST     = GRP_B_LAST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] dout,
    output logic              multi_hot
);

    localparam int unsigned NUM_SRC = SEQ_NUM_SRC;

    logic [NUM_STATES-1:0]          flags;
    src_sel_t                       sel;
    logic [NUM_SRC-1:0][DATA_W-1:0] src_bus;

    seq_flag_chain #(.NUM_STATES(NUM_STATES)) i_chain (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .flags (flags)
    );

    seq_group_decode #(.NUM_STATES(NUM_STATES), .FIRST(A_FIRST), .LAST(A_LAST)) i_grp_a (
        .flags (flags),
        .hit   (sel.hit_a)
    );

    seq_group_decode #(.NUM_STATES(NUM_STATES), .FIRST(B_FIRST), .LAST(B_LAST)) i_grp_b (
        .flags (flags),
        .hit   (sel.hit_b)
    );

    assign src_bus = {src_b, src_a};

    seq_andor_mux #(.NUM_SRC(NUM_SRC), .W(DATA_W)) i_mux (
        .src (src_bus),
        .sel ({sel.hit_b, sel.hit_a}),
        .y   (dout)
    );

    seq_onehot_watch #(.NUM_STATES(NUM_STATES)) i_watch (
        .flags (flags),
        .multi (multi_hot)
    );

endmodule

// File: rtl/onehot_seq_chk.sv
module onehot_seq_chk #(
    parameter int unsigned NUM_STATES = 62,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned A_FIRST    = 33,
    parameter int unsigned A_LAST     = 36,
    parameter int unsigned B_FIRST    = 37,
    parameter int unsigned B_LAST     = 37
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic [NUM_STATES-1:0] flags,
    input logic [DATA_W-1:0]     src_a,
    input logic [DATA_W-1:0]     src_b,
    input logic [DATA_W-1:0]     dout,
    input logic                  multi_hot
);

    logic in_a;
    logic in_b;
    assign in_a = |flags[A_LAST:A_FIRST];
    assign in_b = |flags[B_LAST:B_FIRST];

    // R1 and R9: reset empties the chain, even when start is also high
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (flags == '0));

    // R2 and R7: start loads only the head flag
    p_start_head_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> (flags == NUM_STATES'(1)));

    // R2 and R6: without start, the flag walks up by one
    p_walk_r2: assert property (@(posedge clk) disable iff (rst)
        !start |=> (flags == {$past(flags[NUM_STATES-2:0]), 1'b0}));

    p_sel_a_r3: assert property (@(posedge clk) disable iff (rst)
        in_a |-> (dout == src_a));

    p_sel_b_r4: assert property (@(posedge clk) disable iff (rst)
        in_b |-> (dout == src_b));

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !(in_a || in_b) |-> (dout == '0));

    p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags) && !multi_hot);

endmodule

bind onehot_seq_top onehot_seq_chk #(
    .NUM_STATES (NUM_STATES),
    .DATA_W     (DATA_W),
    .A_FIRST    (A_FIRST),
    .A_LAST     (A_LAST),
    .B_FIRST    (B_FIRST),
    .B_LAST     (B_LAST)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .flags     (flags),
    .src_a     (src_a),
    .src_b     (src_b),
    .dout      (dout),
    .multi_hot (multi_hot)
);

// File: tb/test_onehot_seq_top.sv
module test_onehot_seq_top;

    localparam int W = 16;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
    } vec_t;

    localparam int NVEC = 4;
    localparam vec_t VECS [NVEC] = '{
        '{a: 16'hA5A5, b: 16'h5A5A},
        '{a: 16'hFFFF, b: 16'h0001},
        '{a: 16'h0000, b: 16'hFFFF},
        '{a: 16'h1234, b: 16'h1234}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] src_a = '0;
    logic [W-1:0] src_b = '0;
    logic [W-1:0] dout;
    logic         multi_hot;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    onehot_seq_top i_onehot_seq_top (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .src_a     (src_a),
        .src_b     (src_b),
        .dout      (dout),
        .multi_hot (multi_hot)
    );

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Expected bus for cycle c of a run (R3, R4, R5)
    function automatic logic [W-1:0] expect_bus(input int c, input logic [W-1:0] a, input logic [W-1:0] b);
        if (c >= 33 && c <= 36) return a;
        if (c == 37)            return b;
        return '0;
    endfunction

    function automatic string req_of(input int c);
        if (c >= 33 && c <= 36) return "R3";
        if (c == 37)            return "R4";
        if (c >= 62)            return "R6";
        return "R5";
    endfunction

    // Pulse start; returns at the negedge of cycle 0 (R2)
    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 dout after reset", dout, '0);
        chk("R1 multi_hot after reset", {15'd0, multi_hot}, '0);

        // Table walk: full sequence per source pattern (R2-R6, R8)
        for (int v = 0; v < NVEC; v++) begin
            src_a = VECS[v].a;
            src_b = VECS[v].b;
            pulse_start();
            for (int c = 0; c < 66; c++) begin
                chk(req_of(c), dout, expect_bus(c, VECS[v].a, VECS[v].b));
                chk("R8 multi_hot", {15'd0, multi_hot}, '0);
                @(negedge clk);
            end
        end

        // R5 and R6: sources toggling while idle do not reach the bus
        for (int k = 0; k < 8; k++) begin
            src_a = 16'h1111 << k;
            src_b = 16'h8888 >> k;
            @(negedge clk);
            chk("R6 idle bus", dout, '0);
        end

        // R7: restart while source A is on the bus
        src_a = 16'hC0DE;
        src_b = 16'hBEEF;
        pulse_start();
        repeat (35) @(negedge clk);
        chk("R3 cycle 35 before restart", dout, 16'hC0DE);
        start = 1'b1;
        chk("R3 same cycle as restart", dout, 16'hC0DE);
        @(negedge clk) start = 1'b0;
        for (int c = 0; c < 40; c++) begin
            chk(c == 0 ? "R7 restart cycle 0" : "R7 restarted run", dout, expect_bus(c, 16'hC0DE, 16'hBEEF));
            @(negedge clk);
        end

        // R9: reset and start together inside the A window
        pulse_start();
        repeat (34) @(negedge clk);
        chk("R3 cycle 34 before reset", dout, 16'hC0DE);
        rst = 1'b1;
        start = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        start = 1'b0;
        for (int c = 0; c < 40; c++) begin
            chk("R9 no run after rst with start", dout, '0);
            @(negedge clk);
        end

        // R6: a later start still runs normally
        pulse_start();
        repeat (37) @(negedge clk);
        chk("R6 rerun cycle 37", dout, 16'hBEEF);

        finish_run();
    end

endmodule